// File: doc/BRIEF.md
# Dual-Structure Pseudo-Random Bit Generator

This block is a 16-bit maximal-length linear feedback shift register. One state register can run in two shift structures, picked by an input. The first is the external-XOR structure: the tapped bits are combined and fed into the top bit. The second is the internal-XOR structure: the output bit toggles the tap positions as the register shifts. A second input chooses XOR or XNOR feedback. The generator advances one step on each enabled clock. It gives out its low bit as a serial stream and its whole state as a word.

The feedback polynomial is fixed at x^16 + x^14 + x^13 + x^11 + 1, which is primitive. Every mode therefore visits all 65535 legal states before it repeats. Each feedback type has one state it can never leave: all zeros with XOR, all ones with XNOR. The block keeps out of that state in three places: at reset, when a seed is loaded, and when a step starts from it (for instance after the feedback type changes). In each case it substitutes the default seed 0xACE1 and raises a flag for one cycle.

Top module: `lfsr_dual`

## Requirements
- R1: With synchronous reset high at a clock edge, the state becomes 0xACE1 and the lock flag becomes 0.
- R2: The serial output always equals state bit 0.
- R3: External-XOR mode (structure select 0, feedback select 0): an enabled step shifts the state right by one. The new bit 15 is the XOR of old bits 0, 2, 3 and 5. From 0xACE1 the next state is 0x5670.
- R4: Internal-XOR mode (structure select 1, feedback select 0): an enabled step shifts the state right by one with a 0 entering bit 15. If old bit 0 was 1, the result is then XORed with 0xB400. From 0xACE1 the next state is 0xE270.
- R5: With feedback select 1, either structure produces the bitwise complement of the state sequence that feedback select 0 produces from the complemented seed.
- R6: From a legal seed, every mode comes back to that seed after exactly 65535 enabled steps and not earlier.
- R7: Seed load has priority over enable. A load of a legal seed makes the state equal the seed at the next edge, with the lock flag 0.
- R8: A load of the illegal state (0x0000 under feedback select 0, 0xFFFF under feedback select 1) sets the state to 0xACE1 and the lock flag to 1 for exactly one cycle. The other all-equal value is legal and is loaded as given.
- R9: An enabled step that starts from the state that is illegal for the current feedback select sets the state to 0xACE1 and pulses the lock flag for one cycle.
- R10: With enable and load both low, the state holds and the lock flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Load the seed value (wins over en) |
| seed | input | 16 | Seed value to load |
| galois | input | 1 | Structure select: 0 external XOR, 1 internal XOR |
| xnor_fb | input | 1 | Feedback select: 0 XOR, 1 XNOR |
| bit_o | output | 1 | Serial output stream (state bit 0) |
| state_o | output | 16 | Full register state |
| lock_o | output | 1 | One-cycle pulse when the lock-up state was replaced |

## Verification
Each mode starts from the known seed and is compared, every clock, against a behavioural step model. A single step from 0xACE1 in each structure tells a wrong tap set or a wrong shift direction apart from a correct one. Two full 65535-step runs (external XOR and internal XNOR) check the period. The internal-XNOR run is also compared against the complement of a parallel XOR sequence, which separates a true complementing feedback from one that is merely some other maximal sequence. Further short patterns cover the other cases: all-zero and all-one loads under both feedback types, a feedback switch while parked on the newly illegal state, a load asserted together with enable, and idle cycles.

// File: rtl/lfsr_dual.sv
module lfsr_dual #(
  parameter int                 WIDTH        = 16,
  parameter logic [WIDTH-1:0]   GAL_MASK     = 16'hB400,
  parameter logic [WIDTH-1:0]   DEFAULT_SEED = 16'hACE1,
  parameter logic [WIDTH-1:0]   RESET_SEED   = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             galois,
  input  logic             xnor_fb,
  output logic             bit_o,
  output logic [WIDTH-1:0] state_o,
  output logic             lock_o
);

  function automatic logic [WIDTH-1:0] bit_rev(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  localparam logic [WIDTH-1:0] FIB_TAPS = bit_rev(GAL_MASK);

  logic [WIDTH-1:0] st;
  logic             lock;
  logic [WIDTH-1:0] bad;
  logic             fib_fb;
  logic [WIDTH-1:0] fib_nxt;
  logic [WIDTH-1:0] gal_nxt;
  logic [WIDTH-1:0] step_nxt;

  assign bad      = xnor_fb ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
  assign fib_fb   = (^(st & FIB_TAPS)) ^ xnor_fb;
  assign fib_nxt  = {fib_fb, st[WIDTH-1:1]};
  assign gal_nxt  = {xnor_fb, st[WIDTH-1:1]} ^ ((st[0] ^ xnor_fb) ? GAL_MASK : '0);
  assign step_nxt = galois ? gal_nxt : fib_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= (RESET_SEED == bad) ? DEFAULT_SEED : RESET_SEED;
      lock <= (RESET_SEED == bad);
    end else if (load) begin
      st   <= (seed == bad) ? DEFAULT_SEED : seed;
      lock <= (seed == bad);
    end else if (en) begin
      st   <= (st == bad) ? DEFAULT_SEED : step_nxt;
      lock <= (st == bad);
    end else begin
      lock <= 1'b0;
    end
  end

  assign state_o = st;
  assign bit_o   = st[0];
  assign lock_o  = lock;

  // R7
  load_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (load && seed != bad) |=> (state_o == $past(seed) && !lock_o));

  // R8
  load_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (load && seed == bad) |=> (lock_o && state_o == DEFAULT_SEED));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> ($stable(state_o) && !lock_o));

  // R9
  lock_seed_chk: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> (state_o == DEFAULT_SEED));

  // R3
  fib_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !galois && state_o != bad)
      |=> (state_o[WIDTH-2:0] == $past(state_o[WIDTH-1:1])));

  // R4
  gal_top_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && galois && state_o != bad)
      |=> (state_o[WIDTH-1] == $past(state_o[0])));

endmodule

// File: tb/tb_lfsr_dual.sv
module tb_lfsr_dual;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        load = 1'b0;
  logic [15:0] seed = '0;
  logic        galois = 1'b0;
  logic        xnor_fb = 1'b0;
  logic        bit_o;
  logic [15:0] state_o;
  logic        lock_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] m;
  logic        ml;

  always #4 clk = ~clk;

  lfsr_dual dut (.clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
                 .galois(galois), .xnor_fb(xnor_fb), .bit_o(bit_o),
                 .state_o(state_o), .lock_o(lock_o));

  function automatic logic [15:0] fib_step(input logic [15:0] s, input logic xn);
    logic b;
    b = s[0] ^ s[2] ^ s[3] ^ s[5] ^ xn;
    return (s >> 1) | ({15'd0, b} << 15);
  endfunction

  function automatic logic [15:0] gal_step(input logic [15:0] s, input logic xn);
    logic [15:0] t;
    logic lsb;
    t = xn ? ~s : s;
    lsb = t[0];
    t = t >> 1;
    if (lsb) t = t ^ 16'hB400;
    return xn ? ~t : t;
  endfunction

  task automatic expect_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmp(input string req);
    checks++;
    if (state_o !== m || lock_o !== ml || bit_o !== m[0]) begin
      errors++;
      $display("FAIL %s: actual state %h lock %b bit %b expected state %h lock %b bit %b",
               req, state_o, lock_o, bit_o, m, ml, m[0]);
    end
  endtask

  task automatic cyc(input logic e, input logic l, input logic [15:0] sd, input string req);
    logic [15:0] ill;
    logic [15:0] nm;
    logic        nl;
    en = e; load = l; seed = sd;
    ill = xnor_fb ? 16'hFFFF : 16'h0000;
    nm = m; nl = 1'b0;
    if (l) begin
      if (sd == ill) begin nm = 16'hACE1; nl = 1'b1; end else nm = sd;
    end else if (e) begin
      if (m == ill) begin nm = 16'hACE1; nl = 1'b1; end
      else nm = galois ? gal_step(m, xnor_fb) : fib_step(m, xnor_fb);
    end
    @(posedge clk); #1;
    m = nm; ml = nl;
    cmp(req);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] cpl;
    int first;
    // R1 reset
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    m = 16'hACE1; ml = 1'b0;
    cmp("R1");
    expect_eq("R2", {15'd0, bit_o}, 16'd1);
    rst = 1'b0;

    // R3 single step
    galois = 1'b0; xnor_fb = 1'b0;
    cyc(1, 0, '0, "R3");
    expect_eq("R3", state_o, 16'h5670);

    // R4 single step
    cyc(0, 1, 16'hACE1, "R7");
    galois = 1'b1;
    cyc(1, 0, '0, "R4");
    expect_eq("R4", state_o, 16'hE270);

    // R6 period, external XOR
    galois = 1'b0; xnor_fb = 1'b0;
    cyc(0, 1, 16'hACE1, "R7");
    first = 0;
    for (int i = 1; i <= 65535; i++) begin
      cyc(1, 0, '0, "R3");
      if (first == 0 && state_o == 16'hACE1) first = i;
    end
    expect_eq("R6", first[15:0], 16'hFFFF);

    // R6 period and R5 complement, internal XNOR
    galois = 1'b1; xnor_fb = 1'b1;
    cyc(0, 1, 16'h531E, "R7");
    cpl = 16'hACE1;
    first = 0;
    for (int i = 1; i <= 65535; i++) begin
      cyc(1, 0, '0, "R5");
      cpl = gal_step(cpl, 1'b0);
      checks++;
      if (state_o !== ~cpl) begin
        errors++;
        $display("FAIL R5: actual %h expected %h", state_o, ~cpl);
      end
      if (first == 0 && state_o == 16'h531E) first = i;
    end
    expect_eq("R6", first[15:0], 16'hFFFF);

    // R5 external XNOR complement
    galois = 1'b0; xnor_fb = 1'b1;
    cyc(0, 1, 16'h531E, "R7");
    cpl = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      cyc(1, 0, '0, "R5");
      cpl = fib_step(cpl, 1'b0);
      expect_eq("R5", state_o, ~cpl);
    end

    // R4 internal XOR longer run
    galois = 1'b1; xnor_fb = 1'b0;
    cyc(0, 1, 16'h0001, "R7");
    for (int i = 0; i < 2000; i++) cyc(1, 0, '0, "R4");

    // R7 load beats enable
    cyc(1, 1, 16'h1234, "R7");
    expect_eq("R7", state_o, 16'h1234);

    // R10 hold
    for (int i = 0; i < 5; i++) cyc(0, 0, 16'h0000, "R10");
    expect_eq("R10", state_o, 16'h1234);

    // R8 illegal loads
    xnor_fb = 1'b0;
    cyc(0, 1, 16'h0000, "R8");
    expect_eq("R8", {15'd0, lock_o}, 16'd1);
    cyc(0, 0, 16'h0000, "R8");
    expect_eq("R8", {15'd0, lock_o}, 16'd0);
    xnor_fb = 1'b1;
    cyc(0, 1, 16'hFFFF, "R8");
    expect_eq("R8", state_o, 16'hACE1);
    cyc(0, 0, 16'h0000, "R8");
    xnor_fb = 1'b0;
    cyc(0, 1, 16'hFFFF, "R8");
    expect_eq("R8", state_o, 16'hFFFF);

    // R9 recovery after feedback switch
    xnor_fb = 1'b1; galois = 1'b0;
    cyc(1, 0, '0, "R9");
    expect_eq("R9", state_o, 16'hACE1);
    cyc(1, 0, '0, "R9");
    cyc(0, 1, 16'h0000, "R9");
    expect_eq("R9", state_o, 16'h0000);
    xnor_fb = 1'b0; galois = 1'b1;
    cyc(1, 0, '0, "R9");
    expect_eq("R9", {15'd0, lock_o}, 16'd1);
    cyc(1, 0, '0, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule